// File: doc/BRIEF.md
# Circular Store Queue with Write-Back Pointer

This block keeps the in-flight stores of one thread in program order inside a ring of slots. A store takes a slot at the tail when it is dispatched. Its address, size and data arrive later and are written by slot index. When the retirement logic says that every store older than a given sequence number is final, those stores are marked committed. Committed stores that hold data then go out to memory one per cycle, oldest first. A separate write-back pointer tracks this traffic and sits between head and tail.

The memory port can refuse a request. The block then holds a blocked state until the port sends a retry strobe, and after that it sends the same store again. Memory reports each finished write by slot index. The head pointer moves past every contiguous finished slot in one step, so a slot is freed only after its write has completed, and never at commit. A squash drops every store younger than a given sequence number by pulling the tail back. One slot is always held in reserve, so the ring has one more slot than it has usable entries.

Top module: `stq_ring`

## Requirements
- R1: The ring has ENTRIES+1 slots. `full` is high when `count` equals ENTRIES. An allocation request while full changes neither `count` nor `alloc_idx`.
- R2: Allocating a slot clears its committed, can-write-back and completed flags and its size. A reused slot that is committed but has no data written sends no request until its data is written.
- R3: A data write sets the address, size and data of slot `wr_idx`. These appear on `mem_req_addr`, `mem_req_size` and `mem_req_data` when that slot is sent.
- R4: A commit marks every live store whose sequence number is strictly less than `commit_seq`. `pending_wb` rises by the number of stores newly marked and falls by one for each accepted request.
- R5: `mem_req_valid` is high only when the slot at the write-back pointer is live, committed, holds data (size not zero), is not completed, and the port is not blocked. Requests go out in allocation order, at most one per cycle.
- R6: A request that is refused (`mem_req_valid` high, `mem_req_ready` low) sets `mem_blocked` at the next edge. `mem_blocked` holds and no request is shown until `mem_retry` is pulsed. After that the same slot is offered again.
- R7: `cpl_idx` marks a slot completed. The head then advances over every contiguous completed slot, one cycle after the marking. A completed slot behind an uncompleted older one is not freed.
- R8: A squash removes every live store whose sequence number is greater than `squash_seq`. A store with a sequence number equal to `squash_seq` is kept. The tail and `count` move back to match.
- R9: `head_seq` shows the sequence number of the oldest live store, and shows 0 when the ring is empty.
- R10: All pointers wrap modulo ENTRIES+1. After slot ENTRIES, the allocation index and the write-back index return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a slot at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_idx | output | IDX_W | Slot the next allocation will take |
| wr_valid | input | 1 | Write address, size and data into a slot |
| wr_idx | input | IDX_W | Slot being written |
| wr_addr | input | ADDR_W | Store address |
| wr_size | input | SIZE_W | Store size in bytes |
| wr_data | input | DATA_W | Store data |
| commit_valid | input | 1 | Commit stores older than `commit_seq` |
| commit_seq | input | SEQ_W | Commit boundary (exclusive) |
| squash_valid | input | 1 | Drop stores younger than `squash_seq` |
| squash_seq | input | SEQ_W | Squash boundary (kept) |
| cpl_valid | input | 1 | Memory finished a write |
| cpl_idx | input | IDX_W | Slot whose write finished |
| mem_req_valid | output | 1 | Write request offered to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_retry | input | 1 | Memory can take a refused request again |
| mem_req_idx | output | IDX_W | Slot of the offered request |
| mem_req_addr | output | ADDR_W | Address of the offered request |
| mem_req_size | output | SIZE_W | Size of the offered request |
| mem_req_data | output | DATA_W | Data of the offered request |
| mem_blocked | output | 1 | Port refused a request and awaits retry |
| full | output | 1 | Usable entries exhausted |
| empty | output | 1 | No live store |
| count | output | CNT_W | Number of live stores |
| pending_wb | output | CNT_W | Committed stores not yet accepted by memory |
| head_seq | output | SEQ_W | Sequence number of the oldest store, 0 if empty |

## Verification
The assertions check several properties on every cycle: occupancy never exceeds the usable entries, a full ring freezes the tail, a refused request latches the blocked state, and that state holds the write-back pointer until a retry. They also check that the pending count is never drawn below zero, that the head stays put while its slot is unfinished, and that a slot only completes after it was committed. Some behaviour shows only in the bench's directed scenarios: the exact set of stores selected by a commit or a squash, the order and payload of requests across a wrap, and the resend of the refused slot. So do the freeing of a completed slot that sits behind an older unfinished one, and a reused slot that stays silent until its new data arrives.

// File: rtl/stq_pkg.sv
package stq_pkg;
  // Distance from base to ptr walking forward around a ring of the given depth.
  function automatic int ring_off(int ptr, int base, int depth);
    return (ptr - base + depth) % depth;
  endfunction

  // Pointer reached by stepping n slots forward from ptr.
  function automatic int ring_add(int ptr, int n, int depth);
    return (ptr + n) % depth;
  endfunction
endpackage

// File: rtl/stq_slots.sv
module stq_slots #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 4,
  parameter int SEQ_W  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic [SEQ_W-1:0]  alloc_seq,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit_en,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic [DEPTH-1:0]  live,
  input  logic              cpl_en,
  input  logic [IDX_W-1:0]  cpl_idx,
  output logic [SEQ_W-1:0]  seq_o  [DEPTH],
  output logic [ADDR_W-1:0] addr_o [DEPTH],
  output logic [SIZE_W-1:0] size_o [DEPTH],
  output logic [DATA_W-1:0] data_o [DEPTH],
  output logic [DEPTH-1:0]  done_o,
  output logic [DEPTH-1:0]  canwb_o,
  output logic [CNT_W-1:0]  n_commit
);
  logic [DEPTH-1:0] commit_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              cmt, canwb, done;
    logic [SEQ_W-1:0]  seq;
    logic [ADDR_W-1:0] addr;
    logic [SIZE_W-1:0] size;
    logic [DATA_W-1:0] data;
    logic              hit_alloc, hit_wr, hit_cpl, has_data;

    assign hit_alloc     = alloc_en && (alloc_idx == IDX_W'(g));
    assign hit_wr        = wr_en && (wr_idx == IDX_W'(g));
    assign hit_cpl       = cpl_en && (cpl_idx == IDX_W'(g));
    assign commit_hit[g] = commit_en && live[g] && !cmt && (seq < commit_seq);
    assign has_data      = (size != '0) || (hit_wr && (wr_size != '0));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmt <= 1'b0; canwb <= 1'b0; done <= 1'b0;
        seq <= '0; addr <= '0; size <= '0; data <= '0;
      end else if (hit_alloc) begin
        seq <= alloc_seq;
        cmt <= 1'b0; canwb <= 1'b0; done <= 1'b0; size <= '0;
      end else begin
        if (hit_wr) begin
          addr <= wr_addr; size <= wr_size; data <= wr_data;
        end
        if (commit_hit[g]) cmt <= 1'b1;
        if ((cmt || commit_hit[g]) && has_data) canwb <= 1'b1;
        if (hit_cpl) done <= 1'b1;
      end
    end

    assign seq_o[g]   = seq;
    assign addr_o[g]  = addr;
    assign size_o[g]  = size;
    assign data_o[g]  = data;
    assign done_o[g]  = done;
    assign canwb_o[g] = canwb;

    // R7: a slot finishes its write only after it was committed
    p_done_after_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> cmt);
  end

  assign n_commit = CNT_W'($countones(commit_hit));
endmodule

// File: rtl/stq_wb_gate.sv
module stq_wb_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cand,
  input  logic ready,
  input  logic retry,
  output logic req_valid,
  output logic fire,
  output logic blocked
);
  assign req_valid = cand && !blocked;
  assign fire      = req_valid && ready;

  always_ff @(posedge clk) begin
    if (!rst_n)                   blocked <= 1'b0;
    else if (retry)               blocked <= 1'b0;
    else if (req_valid && !ready) blocked <= 1'b1;
  end

  // R6: blocked state persists until a retry strobe
  p_blocked_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blocked && !retry |=> blocked);
endmodule

// File: rtl/stq_ring.sv
module stq_ring #(
  parameter int ENTRIES = 7,
  parameter int SEQ_W   = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int SIZE_W  = 4,
  localparam int DEPTH  = ENTRIES + 1,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              wr_valid,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              cpl_valid,
  input  logic [IDX_W-1:0]  cpl_idx,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  input  logic              mem_retry,
  output logic [IDX_W-1:0]  mem_req_idx,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [SIZE_W-1:0] mem_req_size,
  output logic [DATA_W-1:0] mem_req_data,
  output logic              mem_blocked,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  pending_wb,
  output logic [SEQ_W-1:0]  head_seq
);
  import stq_pkg::*;

  logic [IDX_W-1:0]  head_q, wb_q, tail_q;
  logic [CNT_W-1:0]  count_q, pend_q, free_n, keep_n, n_commit;
  logic [DEPTH-1:0]  live, done_a, canwb_a;
  logic [SEQ_W-1:0]  seq_a  [DEPTH];
  logic [ADDR_W-1:0] addr_a [DEPTH];
  logic [SIZE_W-1:0] size_a [DEPTH];
  logic [DATA_W-1:0] data_a [DEPTH];
  logic              alloc_fire, wb_cand, wb_fire, wb_live;
  int                wb_off;

  assign full       = (count_q == CNT_W'(ENTRIES));
  assign empty      = (count_q == '0);
  assign alloc_fire = alloc_valid && !full && !squash_valid;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      live[i] = ring_off(i, int'(head_q), DEPTH) < int'(count_q);
  end

  stq_slots #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .SEQ_W(SEQ_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)
  ) u_slots (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(alloc_fire), .alloc_idx(tail_q), .alloc_seq(alloc_seq),
    .wr_en(wr_valid), .wr_idx(wr_idx), .wr_addr(wr_addr),
    .wr_size(wr_size), .wr_data(wr_data),
    .commit_en(commit_valid), .commit_seq(commit_seq), .live(live),
    .cpl_en(cpl_valid), .cpl_idx(cpl_idx),
    .seq_o(seq_a), .addr_o(addr_a), .size_o(size_a), .data_o(data_a),
    .done_o(done_a), .canwb_o(canwb_a), .n_commit(n_commit)
  );

  // Contiguous completed slots from the head, and survivors of a squash.
  always_comb begin
    logic stop, found;
    logic [IDX_W-1:0] idx;
    free_n = '0;
    keep_n = count_q;
    stop   = 1'b0;
    found  = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = IDX_W'(ring_add(int'(head_q), k, DEPTH));
      if (!stop && (CNT_W'(k) < count_q) && done_a[idx]) free_n = free_n + 1'b1;
      else stop = 1'b1;
      if (!found && (CNT_W'(k) < count_q) && (seq_a[idx] > squash_seq)) begin
        keep_n = CNT_W'(k);
        found  = 1'b1;
      end
    end
  end

  assign wb_off  = ring_off(int'(wb_q), int'(head_q), DEPTH);
  assign wb_live = wb_off < int'(count_q);
  assign wb_cand = wb_live && canwb_a[wb_q] && !done_a[wb_q];

  stq_wb_gate u_gate (
    .clk(clk), .rst_n(rst_n), .cand(wb_cand), .ready(mem_req_ready),
    .retry(mem_retry), .req_valid(mem_req_valid), .fire(wb_fire),
    .blocked(mem_blocked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0; wb_q <= '0; tail_q <= '0; count_q <= '0; pend_q <= '0;
    end else begin
      pend_q <= pend_q + n_commit - CNT_W'(wb_fire);
      if (squash_valid) begin
        tail_q  <= IDX_W'(ring_add(int'(head_q), int'(keep_n), DEPTH));
        count_q <= keep_n;
        if (wb_off > int'(keep_n))
          wb_q <= IDX_W'(ring_add(int'(head_q), int'(keep_n), DEPTH));
        else if (wb_fire)
          wb_q <= IDX_W'(ring_add(int'(wb_q), 1, DEPTH));
      end else begin
        if (alloc_fire) tail_q <= IDX_W'(ring_add(int'(tail_q), 1, DEPTH));
        head_q  <= IDX_W'(ring_add(int'(head_q), int'(free_n), DEPTH));
        count_q <= count_q + CNT_W'(alloc_fire) - free_n;
        if (wb_fire) wb_q <= IDX_W'(ring_add(int'(wb_q), 1, DEPTH));
      end
    end
  end

  assign alloc_idx    = tail_q;
  assign count        = count_q;
  assign pending_wb   = pend_q;
  assign head_seq     = empty ? '0 : seq_a[head_q];
  assign mem_req_idx  = wb_q;
  assign mem_req_addr = addr_a[wb_q];
  assign mem_req_size = size_a[wb_q];
  assign mem_req_data = data_a[wb_q];

  // R1: occupancy never passes the usable entry count
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(ENTRIES));
  // R1: a full ring with nothing freed keeps its tail
  p_full_freezes_tail_r1: assert property (@(posedge clk) disable iff (!rst_n)
    full && free_n == '0 && !squash_valid |=> $stable(tail_q));
  // R6: a refused request latches the blocked state
  p_refusal_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready && !mem_retry |=> mem_blocked);
  // R6: while blocked the same slot stays selected
  p_blocked_keeps_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_blocked && !squash_valid |=> $stable(wb_q));
  // R4: an accepted request always has a committed store behind it
  p_pending_covers_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> pend_q != '0);
  // R7: an unfinished head slot pins the head
  p_head_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !squash_valid && !empty && !done_a[head_q] |=> $stable(head_q));
  // R5: the write-back pointer never runs past the tail
  p_wb_inside_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_off <= int'(count_q));
endmodule

// File: tb/stq_ring_test.sv
module stq_ring_test;
  localparam int ENTRIES = 7, SEQ_W = 8, ADDR_W = 16, DATA_W = 32, SIZE_W = 4;
  localparam int IDX_W = 3, CNT_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, wr_valid = 0, commit_valid = 0, squash_valid = 0, cpl_valid = 0;
  logic mem_req_ready = 0, mem_retry = 0;
  logic [SEQ_W-1:0]  alloc_seq = '0, commit_seq = '0, squash_seq = '0;
  logic [IDX_W-1:0]  wr_idx = '0, cpl_idx = '0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [SIZE_W-1:0] wr_size = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [IDX_W-1:0]  alloc_idx, mem_req_idx;
  logic              mem_req_valid, mem_blocked, full, empty;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [SIZE_W-1:0] mem_req_size;
  logic [DATA_W-1:0] mem_req_data;
  logic [CNT_W-1:0]  count, pending_wb;
  logic [SEQ_W-1:0]  head_seq;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  stq_ring #(.ENTRIES(ENTRIES), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W),
             .DATA_W(DATA_W), .SIZE_W(SIZE_W)) uut (.*);

  function automatic logic [ADDR_W-1:0] addr_of(int i); return ADDR_W'(16'h100 + i * 4); endfunction
  function automatic logic [DATA_W-1:0] data_of(int i); return 32'hA500_0000 | DATA_W'(i); endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); #1; endtask
  task automatic do_alloc(int s); alloc_valid = 1; alloc_seq = SEQ_W'(s); cyc(); alloc_valid = 0; endtask
  task automatic do_write(int i);
    wr_valid = 1; wr_idx = IDX_W'(i); wr_addr = addr_of(i); wr_size = 4'd4; wr_data = data_of(i);
    cyc(); wr_valid = 0;
  endtask
  task automatic do_commit(int s); commit_valid = 1; commit_seq = SEQ_W'(s); cyc(); commit_valid = 0; endtask
  task automatic do_squash(int s); squash_valid = 1; squash_seq = SEQ_W'(s); cyc(); squash_valid = 0; endtask
  task automatic do_cpl(int i); cpl_valid = 1; cpl_idx = IDX_W'(i); cyc(); cpl_valid = 0; endtask

  task automatic t_reset();
    chk("R9", "empty after reset", empty, 1);
    chk("R1", "full after reset", full, 0);
    chk("R9", "head_seq after reset", head_seq, 0);
    chk("R10", "alloc_idx after reset", alloc_idx, 0);
    chk("R5", "no request after reset", mem_req_valid, 0);
    chk("R4", "pending after reset", pending_wb, 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < ENTRIES; i++) begin
      chk("R10", "alloc_idx during fill", alloc_idx, i);
      do_alloc(10 + i);
    end
    chk("R1", "count when full", count, ENTRIES);
    chk("R1", "full flag", full, 1);
    do_alloc(99);
    chk("R1", "count after refused alloc", count, ENTRIES);
    chk("R1", "alloc_idx after refused alloc", alloc_idx, ENTRIES);
    chk("R9", "head_seq oldest", head_seq, 10);
  endtask

  task automatic t_squash_part();
    do_squash(12);
    chk("R8", "count after squash keeps equal seq", count, 3);
    chk("R8", "tail after squash", alloc_idx, 3);
    chk("R1", "not full after squash", full, 0);
  endtask

  task automatic t_backpressure();
    do_write(0); do_write(1); do_write(2);
    chk("R5", "no request before commit", mem_req_valid, 0);
    mem_req_ready = 0;
    do_commit(12);
    chk("R4", "pending after commit", pending_wb, 2);
    chk("R5", "request offered", mem_req_valid, 1);
    chk("R3", "request addr", mem_req_addr, addr_of(0));
    chk("R3", "request data", mem_req_data, data_of(0));
    chk("R3", "request size", mem_req_size, 4);
    cyc();
    chk("R6", "blocked after refusal", mem_blocked, 1);
    chk("R6", "no request while blocked", mem_req_valid, 0);
    cyc();
    chk("R6", "still blocked", mem_blocked, 1);
    mem_req_ready = 1; mem_retry = 1; cyc(); mem_retry = 0;
    chk("R6", "unblocked after retry", mem_blocked, 0);
    chk("R6", "resend valid", mem_req_valid, 1);
    chk("R6", "resend same slot", mem_req_idx, 0);
    cyc();
    chk("R5", "next request in order", mem_req_idx, 1);
    chk("R4", "pending after one accept", pending_wb, 1);
    cyc();
    chk("R5", "uncommitted slot not sent", mem_req_valid, 0);
    chk("R4", "pending drained", pending_wb, 0);
  endtask

  task automatic t_complete();
    do_cpl(1); cyc();
    chk("R7", "younger completion frees nothing", count, 3);
    chk("R7", "head unchanged", head_seq, 10);
    do_cpl(0); cyc();
    chk("R7", "contiguous completions freed", count, 1);
    chk("R9", "head_seq after free", head_seq, 12);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 6; i++) begin
      chk("R10", "alloc_idx across wrap", alloc_idx, (3 + i) % (ENTRIES + 1));
      do_alloc(20 + i);
    end
    chk("R10", "alloc_idx wrapped", alloc_idx, 1);
    chk("R1", "full again", full, 1);
    for (int i = 3; i < 8; i++) do_write(i);
    do_commit(26);
    chk("R4", "commit counts all older", pending_wb, 7);
    for (int i = 2; i < 8; i++) begin
      chk("R5", "request valid in stream", mem_req_valid, 1);
      chk("R5", "request order", mem_req_idx, i);
      chk("R3", "stream addr", mem_req_addr, addr_of(i));
      cyc();
    end
    chk("R2", "reused slot without data silent", mem_req_valid, 0);
    chk("R2", "one store waiting", pending_wb, 1);
    do_write(0);
    chk("R10", "write-back pointer wrapped", mem_req_idx, 0);
    chk("R2", "reused slot sends after data", mem_req_valid, 1);
    chk("R3", "reused slot data", mem_req_data, data_of(0));
    cyc();
    chk("R4", "all accepted", pending_wb, 0);
    do_cpl(2);
    for (int i = 3; i < 8; i++) do_cpl(i);
    do_cpl(0); cyc();
    chk("R7", "all freed", count, 0);
    chk("R9", "empty", empty, 1);
    chk("R9", "head_seq zero when empty", head_seq, 0);
  endtask

  task automatic t_squash_all();
    do_alloc(40); do_alloc(41); do_alloc(42);
    chk("R8", "count before full squash", count, 3);
    do_squash(39);
    chk("R8", "full squash empties", empty, 1);
    chk("R8", "tail restored", alloc_idx, 1);
  endtask

  initial begin
    #(20 * 5000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R5 watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    rst_n = 1;
    cyc();
    t_reset();
    t_fill();
    t_squash_part();
    t_backpressure();
    t_complete();
    t_wrap();
    t_squash_all();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule